// File: doc/BRIEF.md
# Two-Size Sequential-Probe Translation Buffer

This block is a 4-way, 16-set translation buffer whose single storage array holds both 4 KB and 2 MB translations side by side. Every entry keeps a size flag next to its tag and frame. A lookup walks through the page sizes one at a time. The first probe indexes the array as though the page were 4 KB. Only when that probe misses is a second probe made with 2 MB indexing. The lookup ends at the first hit, or once both sizes have missed.

A 4 KB hit therefore answers after one probe. A 2 MB hit, or a full miss, takes two probes. The response reports the probe count so that the requester can see this latency. Translations are written through a separate fill port. Each fill goes into the set picked by the index function for its own size. When the set is full, the fill replaces the least recently used way.

The control is a four-state machine:
- IDLE accepts a request and moves to PROBE_SMALL.
- PROBE_SMALL goes to RESPOND on a hit, or to PROBE_LARGE on a miss.
- PROBE_LARGE always goes to RESPOND.
- RESPOND presents the result for one cycle and returns to IDLE.

Top module: `tlbhr_top`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, and no entry is valid, so any lookup misses.
- R2: resp_valid is high for exactly one cycle per accepted request. It appears after the first clock edge following the accepting edge when resp_probes is 1, and after the second edge when resp_probes is 2.
- R3: A 2 MB hit reports resp_hit=1, resp_big=1 and resp_probes=2, with resp_pa = {frame[19:9], va[20:0]}.
- R4: A lookup that matches no entry reports resp_hit=0 and resp_probes=2.
- R5: An entry matches only a probe of its own size. A 2 MB entry whose stored set and tag equal the 4 KB set and tag of an address does not hit that address.
- R6: The 4 KB probe uses set va[15:12] and compares tag va[31:16]. The 2 MB probe uses set va[24:21] and compares tag va[31:25]. Addresses that differ only in their tag bits do not hit each other.
- R7: A fill with fill_big=1 is written into set fill_va[24:21], and leaves the set fill_va[15:12] untouched.
- R8: A fill uses the lowest-numbered invalid way of its set. When the set has no invalid way, the fill replaces the least recently used way, where both hits and fills count as uses.
- R9: req_ready is 0 from the accepting edge until the lookup has responded. A request offered while req_ready is 0 is ignored and produces no response.
- R10: A 4 KB hit reports resp_hit=1, resp_big=0 and resp_probes=1, with resp_pa = {frame, va[11:0]}.
- R11: A 2 MB entry hits any address in its 2 MB page, regardless of va[20:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | High when a request can be accepted |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_hit | output | 1 | Translation found |
| resp_pa | output | 32 | Physical address (0 on miss) |
| resp_big | output | 1 | Hit was a 2 MB page |
| resp_probes | output | 2 | Probes used (1 or 2) |
| fill_valid | input | 1 | Write one translation |
| fill_va | input | 32 | Virtual address of the translation |
| fill_pfn | input | 20 | 4 KB frame number (upper 11 bits used for 2 MB pages) |
| fill_big | input | 1 | Translation is a 2 MB page |

## Verification
The bench places a 2 MB entry whose 2 MB set and tag equal the 4 KB set and tag of another address. A design that ignored the size flag would hit on the first probe there, instead of missing after two. It fills a set to capacity, refreshes one way with a hit, and then fills a fifth translation. A design with wrong recency tracking evicts a recently used way rather than the stale one. It fills a 2 MB page whose address would land in that full 4 KB set, and then checks that all four small entries survive; a fill using the wrong index would evict one. It also holds a request across a busy cycle, where a design without the ready gating would return a second, unexpected response. Every response is checked against its expected arrival cycle, so an extra or missing probe shows up as a latency error.

// File: rtl/tlbhr_pkg.sv
package tlbhr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_PROBE_SMALL = 2'd1,
        ST_PROBE_LARGE = 2'd2,
        ST_RESPOND     = 2'd3
    } tlbhr_state_e;
endpackage

// File: rtl/tlbhr_index.sv
// Set and tag extraction for one page size; the large tag is zero-extended.
module tlbhr_index #(
    parameter int VA_W      = 32,
    parameter int SET_W     = 4,
    parameter int TAG_W     = 16,
    parameter int SMALL_OFS = 12,
    parameter int LARGE_OFS = 21
) (
    input  logic [VA_W-1:0]  va,
    input  logic             big,
    output logic [SET_W-1:0] set_idx,
    output logic [TAG_W-1:0] tag
);
    localparam int LTAG_W = VA_W - LARGE_OFS - SET_W;

    always_comb begin
        if (big) begin
            set_idx = va[LARGE_OFS +: SET_W];
            tag     = {{(TAG_W-LTAG_W){1'b0}}, va[VA_W-1 -: LTAG_W]};
        end else begin
            set_idx = va[SMALL_OFS +: SET_W];
            tag     = va[VA_W-1 -: TAG_W];
        end
    end
endmodule

// File: rtl/tlbhr_array.sv
// Entry storage, per-way compare, victim choice and age-based LRU.
module tlbhr_array #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int PFN_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  lk_set,
    input  logic [TAG_W-1:0]         lk_tag,
    input  logic                     lk_big,
    input  logic                     lk_upd,
    output logic                     lk_hit,
    output logic [PFN_W-1:0]         lk_pfn,
    input  logic                     fl_en,
    input  logic [$clog2(SETS)-1:0]  fl_set,
    input  logic [TAG_W-1:0]         fl_tag,
    input  logic                     fl_big,
    input  logic [PFN_W-1:0]         fl_pfn
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int AGE_W = WAY_W;

    logic [WAYS-1:0]  v_q   [SETS];
    logic [WAYS-1:0]  big_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PFN_W-1:0] pfn_q [SETS][WAYS];
    logic [AGE_W-1:0] age_q [SETS][WAYS];

    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] vic;
    logic             t_en;
    logic [SET_W-1:0] t_set;
    logic [WAY_W-1:0] t_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = v_q[lk_set][w] && (big_q[lk_set][w] == lk_big)
                          && (tag_q[lk_set][w] == lk_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS-1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign lk_hit = |match;
    assign lk_pfn = pfn_q[lk_set][hit_way];

    always_comb begin
        logic found;
        found = 1'b0;
        vic   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !v_q[fl_set][w]) begin
                vic   = WAY_W'(w);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[fl_set][w] == AGE_W'(WAYS-1)) vic = WAY_W'(w);
            end
        end
    end

    // A fill and a hit in the same cycle: the fill owns the recency update.
    always_comb begin
        t_en  = fl_en || (lk_upd && lk_hit);
        t_set = fl_en ? fl_set : lk_set;
        t_way = fl_en ? vic : hit_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                v_q[s]   <= '0;
                big_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    pfn_q[s][w] <= '0;
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            if (t_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == t_way)
                        age_q[t_set][w] <= '0;
                    else if (age_q[t_set][w] < age_q[t_set][t_way])
                        age_q[t_set][w] <= age_q[t_set][w] + AGE_W'(1);
                end
            end
            if (fl_en) begin
                v_q[fl_set][vic]   <= 1'b1;
                big_q[fl_set][vic] <= fl_big;
                tag_q[fl_set][vic] <= fl_tag;
                pfn_q[fl_set][vic] <= fl_pfn;
            end
        end
    end

    // R8: the way just filled becomes the most recently used one
    a_r8_fill_newest: assert property (@(posedge clk) disable iff (!rst_n)
        fl_en |=> age_q[$past(fl_set)][$past(vic)] == '0);

    // R8: the victim of a fill never holds a younger way than the oldest
    a_r8_victim_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && (&v_q[fl_set])) |-> age_q[fl_set][vic] == AGE_W'(WAYS-1));
endmodule

// File: rtl/tlbhr_top.sv
module tlbhr_top #(
    parameter int VA_W = 32,
    parameter int PA_W = 32,
    parameter int SETS = 16,
    parameter int WAYS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_va,
    output logic                 req_ready,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [PA_W-1:0]      resp_pa,
    output logic                 resp_big,
    output logic [1:0]           resp_probes,
    input  logic                 fill_valid,
    input  logic [VA_W-1:0]      fill_va,
    input  logic [PA_W-13:0]     fill_pfn,
    input  logic                 fill_big
);
    import tlbhr_pkg::*;

    localparam int SMALL_OFS = 12;
    localparam int LARGE_OFS = 21;
    localparam int SET_W     = $clog2(SETS);
    localparam int TAG_W     = VA_W - SMALL_OFS - SET_W;
    localparam int PFN_W     = PA_W - SMALL_OFS;
    localparam int LFRM_W    = PA_W - LARGE_OFS;

    tlbhr_state_e state_q, state_d;
    logic [VA_W-1:0]  va_q;
    logic             r_hit, r_big;
    logic [PA_W-1:0]  r_pa;
    logic [1:0]       r_probes;

    logic [SET_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    logic             lk_big, lk_upd, lk_hit;
    logic [PFN_W-1:0] lk_pfn;

    assign lk_big = (state_q == ST_PROBE_LARGE);
    assign lk_upd = (state_q == ST_PROBE_SMALL) || (state_q == ST_PROBE_LARGE);

    tlbhr_index #(.VA_W(VA_W), .SET_W(SET_W), .TAG_W(TAG_W),
                  .SMALL_OFS(SMALL_OFS), .LARGE_OFS(LARGE_OFS)) u_lk_idx (
        .va(va_q), .big(lk_big), .set_idx(lk_set), .tag(lk_tag));

    tlbhr_index #(.VA_W(VA_W), .SET_W(SET_W), .TAG_W(TAG_W),
                  .SMALL_OFS(SMALL_OFS), .LARGE_OFS(LARGE_OFS)) u_fl_idx (
        .va(fill_va), .big(fill_big), .set_idx(fl_set), .tag(fl_tag));

    tlbhr_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .lk_set(lk_set), .lk_tag(lk_tag), .lk_big(lk_big), .lk_upd(lk_upd),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .fl_en(fill_valid), .fl_set(fl_set), .fl_tag(fl_tag),
        .fl_big(fill_big), .fl_pfn(fill_pfn));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (req_valid) state_d = ST_PROBE_SMALL;
            ST_PROBE_SMALL: state_d = lk_hit ? ST_RESPOND : ST_PROBE_LARGE;
            ST_PROBE_LARGE: state_d = ST_RESPOND;
            ST_RESPOND:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and probe result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q     <= '0;
            r_hit    <= 1'b0;
            r_big    <= 1'b0;
            r_pa     <= '0;
            r_probes <= 2'd0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) va_q <= req_va;
                ST_PROBE_SMALL: begin
                    r_hit    <= lk_hit;
                    r_big    <= 1'b0;
                    r_probes <= 2'd1;
                    r_pa     <= lk_hit ? {lk_pfn, va_q[SMALL_OFS-1:0]} : '0;
                end
                ST_PROBE_LARGE: begin
                    r_hit    <= lk_hit;
                    r_big    <= lk_hit;
                    r_probes <= 2'd2;
                    r_pa     <= lk_hit ? {lk_pfn[PFN_W-1 -: LFRM_W], va_q[LARGE_OFS-1:0]} : '0;
                end
                ST_RESPOND: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        resp_valid  = (state_q == ST_RESPOND);
        resp_hit    = r_hit;
        resp_big    = r_big;
        resp_pa     = r_pa;
        resp_probes = r_probes;
    end

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_resp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r4_miss_two_probes: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> resp_probes == 2'd2);

    a_r10_one_probe_small: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_probes == 2'd1) |-> (resp_hit && !resp_big));

    a_r3_big_two_probes: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_big) |-> (resp_hit && resp_probes == 2'd2));
endmodule

// File: tb/tb_tlbhr_top.sv
module tb_tlbhr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready, resp_valid, resp_hit, resp_big;
    logic [31:0] resp_pa;
    logic [1:0]  resp_probes;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_va = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_big = 1'b0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        logic        big;
        logic [1:0]  probes;
        int          at;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tlbhr_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_pa(resp_pa), .resp_big(resp_big), .resp_probes(resp_probes),
        .fill_valid(fill_valid), .fill_va(fill_va), .fill_pfn(fill_pfn),
        .fill_big(fill_big));

    function automatic logic [31:0] pa_small(input logic [19:0] f, input logic [31:0] va);
        return {f, va[11:0]};
    endfunction
    function automatic logic [31:0] pa_big(input logic [19:0] f, input logic [31:0] va);
        return {f[19:9], va[20:0]};
    endfunction

    // monitor: compare each response against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R9 unexpected response: actual hit=%0b pa=%h expected none",
                         resp_hit, resp_pa);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (resp_hit !== e.hit || resp_probes !== e.probes || cyc != e.at ||
                    (e.hit && (resp_pa !== e.pa || resp_big !== e.big))) begin
                    bad++;
                    $display("FAIL %s: actual hit=%0b pa=%h big=%0b probes=%0d cyc=%0d expected hit=%0b pa=%h big=%0b probes=%0d cyc=%0d",
                             e.req, resp_hit, resp_pa, resp_big, resp_probes, cyc,
                             e.hit, e.pa, e.big, e.probes, e.at);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [19:0] f, input logic big);
        @(negedge clk);
        fill_valid = 1'b1; fill_va = va; fill_pfn = f; fill_big = big;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] va, input logic hit,
                          input logic [31:0] pa, input logic big, input logic [1:0] probes);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        e.hit = hit; e.pa = pa; e.big = big; e.probes = probes;
        e.at = cyc + 1 + int'(probes); e.req = req;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 req_ready", {31'd0, req_ready}, 32'd1);
        check("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
        lookup("R1 R4 empty miss", 32'h1234_7ABC, 1'b0, '0, 1'b0, 2'd2);

        // R10 R2 small hit in one probe
        do_fill(32'h1234_7000, 20'hABCDE, 1'b0);
        lookup("R10 R2 small hit", 32'h1234_7ABC, 1'b1, pa_small(20'hABCDE, 32'h1234_7ABC), 1'b0, 2'd1);
        // R6 tag differs only
        lookup("R6 tag mismatch", 32'h9234_7ABC, 1'b0, '0, 1'b0, 2'd2);

        // R3 R11 big hit anywhere in page, low frame bits dropped
        do_fill(32'h0460_0000, 20'h554FF, 1'b1);
        lookup("R3 big hit", 32'h0467_8ABC, 1'b1, pa_big(20'h554FF, 32'h0467_8ABC), 1'b1, 2'd2);
        lookup("R11 big hit other offset", 32'h047F_F001, 1'b1, pa_big(20'h554FF, 32'h047F_F001), 1'b1, 2'd2);
        lookup("R6 big tag mismatch", 32'h8460_0000, 1'b0, '0, 1'b0, 2'd2);

        // R5 big entry with set 3 / tag 3 must not hit small probe set 3 / tag 3
        do_fill(32'h0660_0000, 20'h77700, 1'b1);
        lookup("R5 size flag", 32'h0003_3000, 1'b0, '0, 1'b0, 2'd2);

        // R8 LRU in small set 5
        do_fill(32'h0001_5000, 20'h11111, 1'b0);
        do_fill(32'h0002_5000, 20'h22222, 1'b0);
        do_fill(32'h0003_5000, 20'h33333, 1'b0);
        do_fill(32'h0004_5000, 20'h44444, 1'b0);
        lookup("R8 refresh A", 32'h0001_5010, 1'b1, pa_small(20'h11111, 32'h0001_5010), 1'b0, 2'd1);
        do_fill(32'h0005_5000, 20'h55555, 1'b0);
        lookup("R8 B evicted", 32'h0002_5000, 1'b0, '0, 1'b0, 2'd2);
        lookup("R8 E present", 32'h0005_5020, 1'b1, pa_small(20'h55555, 32'h0005_5020), 1'b0, 2'd1);

        // R7 big fill whose small index would be set 5 goes to big set 0
        do_fill(32'h0A00_5000, 20'h99900, 1'b1);
        lookup("R7 A kept", 32'h0001_5004, 1'b1, pa_small(20'h11111, 32'h0001_5004), 1'b0, 2'd1);
        lookup("R7 C kept", 32'h0003_5004, 1'b1, pa_small(20'h33333, 32'h0003_5004), 1'b0, 2'd1);
        lookup("R7 D kept", 32'h0004_5004, 1'b1, pa_small(20'h44444, 32'h0004_5004), 1'b0, 2'd1);
        lookup("R7 E kept", 32'h0005_5004, 1'b1, pa_small(20'h55555, 32'h0005_5004), 1'b0, 2'd1);
        lookup("R7 big present", 32'h0A12_3456, 1'b1, pa_big(20'h99900, 32'h0A12_3456), 1'b1, 2'd2);

        // R9 request held while busy is ignored
        begin
            exp_t e;
            @(negedge clk);
            req_valid = 1'b1; req_va = 32'h7777_0000;
            e.hit = 1'b0; e.pa = '0; e.big = 1'b0; e.probes = 2'd2;
            e.at = cyc + 3; e.req = "R9 busy miss";
            sb.push_back(e);
            @(negedge clk);
            req_va = 32'h1234_7000;
            check("R9 ready low while busy", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            req_valid = 1'b0;
            while (sb.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            check("R9 ready back", {31'd0, req_ready}, 32'd1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule